// File: doc/BRIEF.md
# Write-through invalidate snooping cache controller

This block manages a small direct-mapped cache that sits beside one processor on a shared bus. Every line is either Valid or Invalid. A processor read finds its line by the low address bits; a read that hits returns the cached word without touching the bus. A read that misses requests the bus, issues a bus read and installs the returned word. Every processor write goes out on the bus as a bus write, whether or not the line is present. A write to a line that is present also updates the cached word. A write to a line that is absent does not allocate it.

The block also watches the bus writes issued by other caches on the snoop input. When such a write names a block that this cache holds, that line becomes Invalid, and the block puts nothing on the bus in response. Any number of caches may therefore hold the same block at once, and each drops its copy when someone else writes it.

A processor request that needs the bus waits in a pending state until the grant arrives. Snoops are still applied during that wait. When a snoop names the very block that a pending read is about to fill, the fill is discarded and the bus read is issued again, so a stale word never lands in the cache.

Top module: `wti_cache_ctrl`

## Requirements
- R1: While reset is held, and after it is released, every line is Invalid. No bus request and no response are raised, and the processor port is ready. The first read to any address is therefore a miss.
- R2: A processor read that misses keeps `bus_req` high with `bus_wr`=0 (0 means read, 1 means write) and `bus_addr` equal to the request address. One cycle after the grant cycle, it returns the `bus_rdata` sampled at the grant and installs that word as Valid.
- R3: A processor read that hits a Valid line raises `cpu_resp_valid` one cycle after the request is accepted, with the cached word, and never raises `bus_req`.
- R4: Every processor write raises `bus_req` with `bus_wr`=1, the request address and the write data, and responds one cycle after the grant cycle.
- R5: A write to a Valid line with a matching tag replaces the cached word, and the line stays Valid.
- R6: A snooped bus write whose address matches a Valid line makes that line Invalid on the next edge and causes no bus request or response.
- R7: A write to an Invalid line leaves it Invalid; a later read of that address misses.
- R8: The address is split with the low `IDX_W` bits as line index and the rest as tag, for processor and snoop accesses alike. A snoop on the same index with a different tag leaves the line Valid and its data unchanged.
- R9: While a request is pending, `bus_req` stays high and bus address, command and data stay stable until the grant. `cpu_req_ready` is low during this time, and snoops still invalidate lines.
- R10: If a snoop matches the address of a pending read, in any cycle up to and including the grant cycle, the grant is not installed and no response is given. The bus read is requested again, and the next grant completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_wr | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address (tag above, index in low IDX_W bits) |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_req_ready | output | 1 | Block accepts a request this cycle |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read result (zero for writes) |
| bus_req | output | 1 | Bus request, held until granted |
| bus_wr | output | 1 | Bus command: 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_gnt | input | 1 | Grant; the transaction happens in this cycle |
| bus_rdata | input | DATA_W | Read data, valid in the grant cycle |
| snp_valid | input | 1 | A bus write by another cache is seen |
| snp_addr | input | ADDR_W | Address of that snooped write |

## Verification
A read hit is due one clock edge after the edge that accepts it. A miss or a write shows its bus request one edge after acceptance, and its response one edge after the grant edge. A snoop changes the line state at the edge that samples it. The bench drives every input on the falling edge and reads the outputs at the next falling edge after the rising edge that is due to produce them. For pending requests, it holds the grant low for a chosen number of cycles and checks the bus outputs at each of them. A retried fill is checked in the cycle after the first grant, before the second grant is given.

// File: rtl/wti_pkg.sv
`timescale 1ns/1ps
package wti_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } ctl_st_e;
endpackage

// File: rtl/wti_line_store.sv
`timescale 1ns/1ps
module wti_line_store #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_line_hit,
  input  logic              fill_en,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  vld_w;
  logic [TAG_W-1:0]  tag_w [LINES];
  logic [DATA_W-1:0] dat_w [LINES];

  logic [IDX_W-1:0] wr_idx, lk_idx, sn_idx;
  logic [TAG_W-1:0] wr_tag, lk_tag, sn_tag;

  assign wr_idx = wr_addr[IDX_W-1:0];
  assign wr_tag = wr_addr[ADDR_W-1:IDX_W];
  assign lk_idx = lk_addr[IDX_W-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:IDX_W];
  assign sn_idx = snp_addr[IDX_W-1:0];
  assign sn_tag = snp_addr[ADDR_W-1:IDX_W];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              v_q, v_d;
    logic [TAG_W-1:0]  t_q, t_d;
    logic [DATA_W-1:0] d_q, d_d;
    logic              sel_fill, sel_upd, sel_inv, en_td;

    always_comb begin
      sel_fill = fill_en && (wr_idx == IDX_W'(i));
      sel_upd  = upd_en && (wr_idx == IDX_W'(i)) && v_q && (t_q == wr_tag);
      sel_inv  = inv_en && (inv_idx == IDX_W'(i));
      v_d = v_q;
      if (sel_inv)  v_d = 1'b0;
      if (sel_fill) v_d = 1'b1;
      en_td = sel_fill || sel_upd;
      t_d   = sel_fill ? wr_tag : t_q;
      d_d   = sel_fill ? fill_data : upd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (en_td) begin
        t_q <= t_d;
        d_q <= d_d;
      end
    end

    assign vld_w[i] = v_q;
    assign tag_w[i] = t_q;
    assign dat_w[i] = d_q;
  end

  assign lk_hit       = vld_w[lk_idx] && (tag_w[lk_idx] == lk_tag);
  assign lk_data      = dat_w[lk_idx];
  assign snp_line_hit = vld_w[sn_idx] && (tag_w[sn_idx] == sn_tag);

  // R6
  snoop_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !fill_en) |=> !vld_w[$past(inv_idx)]);
endmodule

// File: rtl/wti_snoop_unit.sv
`timescale 1ns/1ps
module wti_snoop_unit #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_line_hit,
  input  logic              pend_rd,
  input  logic [ADDR_W-1:0] pend_addr,
  output logic              inv_en,
  output logic [IDX_W-1:0]  inv_idx,
  output logic              pend_hit
);
  // R8: only a full index+tag match invalidates
  assign inv_en   = snp_valid && snp_line_hit;
  assign inv_idx  = snp_addr[IDX_W-1:0];
  // R10: a pending read fill is spoiled by a write to its block
  assign pend_hit = snp_valid && pend_rd && (snp_addr == pend_addr);
endmodule

// File: rtl/wti_ctrl_fsm.sv
`timescale 1ns/1ps
module wti_ctrl_fsm
  import wti_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_wr,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              pend_hit,
  output logic              pend_rd,
  output logic              fill_en,
  output logic              upd_en
);
  ctl_st_e           st_q, st_d;
  logic              p_wr_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [DATA_W-1:0] p_data_q;
  logic              kill_q, kill_d;
  logic              rsp_v_q, rsp_v_d;
  logic [DATA_W-1:0] rsp_d_q, rsp_d_d;
  logic              accept, rd_hit_now, go_pend, gnt_now, retry, complete;

  always_comb begin
    accept     = (st_q == ST_IDLE) && cpu_req_valid;
    rd_hit_now = accept && !cpu_req_wr && lk_hit;
    go_pend    = accept && !rd_hit_now;
    gnt_now    = (st_q == ST_PEND) && bus_gnt;
    retry      = gnt_now && !p_wr_q && (kill_q || pend_hit);
    complete   = gnt_now && !retry;
    fill_en    = complete && !p_wr_q;
    upd_en     = complete && p_wr_q;

    st_d = st_q;
    case (st_q)
      ST_IDLE: if (go_pend)  st_d = ST_PEND;
      ST_PEND: if (complete) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase

    kill_d  = (st_q == ST_PEND) && !gnt_now && (kill_q || pend_hit);
    rsp_v_d = rd_hit_now || complete;
    rsp_d_d = rd_hit_now ? lk_data : (fill_en ? bus_rdata : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kill_q  <= 1'b0;
      rsp_v_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      kill_q  <= kill_d;
      rsp_v_q <= rsp_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (go_pend) begin
      p_wr_q   <= cpu_req_wr;
      p_addr_q <= cpu_req_addr;
      p_data_q <= cpu_req_wdata;
    end
    if (rsp_v_d) rsp_d_q <= rsp_d_d;
  end

  assign cpu_req_ready  = (st_q == ST_IDLE);
  assign cpu_resp_valid = rsp_v_q;
  assign cpu_resp_rdata = rsp_d_q;
  assign bus_req        = (st_q == ST_PEND);
  assign bus_wr         = p_wr_q;
  assign bus_addr       = p_addr_q;
  assign bus_wdata      = p_data_q;
  assign lk_addr        = (st_q == ST_IDLE) ? cpu_req_addr : p_addr_q;
  assign pend_rd        = (st_q == ST_PEND) && !p_wr_q;

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && !cpu_req_ready &&
      $stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata)));
  // R10
  fill_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !bus_wr && pend_hit) |=> (bus_req && !cpu_resp_valid));
  // R4
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_wr) |=> (cpu_resp_valid && !bus_req));
  // R2
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (cpu_resp_valid && cpu_resp_rdata == $past(bus_rdata)));
endmodule

// File: rtl/wti_cache_ctrl.sv
`timescale 1ns/1ps
module wti_cache_ctrl #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_wr,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr
);
  logic [1:0]        rs_q;
  logic              rst_in_n;
  logic              lk_hit, snp_line_hit, pend_hit, pend_rd;
  logic              fill_en, upd_en, inv_en;
  logic [IDX_W-1:0]  inv_idx;
  logic [ADDR_W-1:0] lk_addr;
  logic [DATA_W-1:0] lk_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_in_n = rs_q[1];

  wti_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_in_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_wr(cpu_req_wr),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_rdata(cpu_resp_rdata),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .lk_hit(lk_hit), .lk_data(lk_data), .lk_addr(lk_addr),
    .pend_hit(pend_hit), .pend_rd(pend_rd),
    .fill_en(fill_en), .upd_en(upd_en)
  );

  wti_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_in_n),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .snp_addr(snp_addr), .snp_line_hit(snp_line_hit),
    .fill_en(fill_en), .upd_en(upd_en), .wr_addr(bus_addr),
    .fill_data(bus_rdata), .upd_data(bus_wdata),
    .inv_en(inv_en), .inv_idx(inv_idx)
  );

  wti_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_line_hit(snp_line_hit),
    .pend_rd(pend_rd), .pend_addr(bus_addr),
    .inv_en(inv_en), .inv_idx(inv_idx), .pend_hit(pend_hit)
  );

  // R3
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    (cpu_req_valid && cpu_req_ready && !cpu_req_wr && lk_hit)
      |=> (cpu_resp_valid && !bus_req));
endmodule

// File: tb/sim_wti_cache_ctrl.sv
`timescale 1ns/1ps
module sim_wti_cache_ctrl;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NV = 13;

  logic          clk, rst_n;
  logic          cpu_req_valid, cpu_req_wr;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic          cpu_req_ready, cpu_resp_valid;
  logic [DW-1:0] cpu_resp_rdata;
  logic          bus_req, bus_wr, bus_gnt;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          snp_valid;
  logic [AW-1:0] snp_addr;

  int n_cmp = 0;
  int n_bad = 0;

  wti_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(3)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_wr(cpu_req_wr),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_rdata(cpu_resp_rdata),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // op: 0 read, 1 write, 2 snoop; bus kind: 0 none, 1 read, 2 write
  // fields: {req_no[3:0], op[1:0], addr[11:0], data[31:0], exp[31:0], bus[1:0]}
  localparam logic [83:0] VEC [NV] = '{
    {4'd2, 2'd0, 12'h015, 32'h11111111, 32'h11111111, 2'd1}, // R1 R2 cold miss
    {4'd3, 2'd0, 12'h015, 32'h0,        32'h11111111, 2'd0}, // R3 hit
    {4'd4, 2'd1, 12'h015, 32'h22222222, 32'h0,        2'd2}, // R4 write on bus
    {4'd5, 2'd0, 12'h015, 32'h0,        32'h22222222, 2'd0}, // R5 updated copy
    {4'd8, 2'd2, 12'h025, 32'h0,        32'h0,        2'd0}, // R8 other tag snoop
    {4'd8, 2'd0, 12'h015, 32'h0,        32'h22222222, 2'd0}, // R8 still valid
    {4'd6, 2'd2, 12'h015, 32'h0,        32'h0,        2'd0}, // R6 snoop hit
    {4'd6, 2'd0, 12'h015, 32'h33333333, 32'h33333333, 2'd1}, // R6 now misses
    {4'd7, 2'd1, 12'h013, 32'h44444444, 32'h0,        2'd2}, // R7 write miss
    {4'd7, 2'd0, 12'h013, 32'h55555555, 32'h55555555, 2'd1}, // R7 not allocated
    {4'd2, 2'd0, 12'h025, 32'h66666666, 32'h66666666, 2'd1}, // R2 conflict fill
    {4'd2, 2'd0, 12'h015, 32'h77777777, 32'h77777777, 2'd1}, // R2 evicted
    {4'd2, 2'd0, 12'h025, 32'h88888888, 32'h88888888, 2'd1}  // R2 evicted
  };

  task automatic do_snoop(input logic [AW-1:0] a, input string rq);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    chk(!bus_req && !cpu_resp_valid, rq, {30'd0, bus_req, cpu_resp_valid}, 0);
  endtask

  task automatic do_access(input bit wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input int gdly, input string rq,
                           output int kind, output logic [DW-1:0] rd, output bit got);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_wr = wr; cpu_req_addr = a; cpu_req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    kind = 0; got = 1'b0; rd = '0;
    if (cpu_resp_valid) begin
      got = 1'b1; rd = cpu_resp_rdata;
    end else if (bus_req) begin
      kind = bus_wr ? 2 : 1;
      chk(bus_addr == a, rq, DW'(bus_addr), DW'(a));
      if (wr) chk(bus_wdata == d, rq, bus_wdata, d);
      for (int g = 0; g < gdly; g++) @(negedge clk);
      bus_gnt = 1'b1; bus_rdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_gnt = 1'b0;
      got = cpu_resp_valid; rd = cpu_resp_rdata;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int            kind;
    logic [DW-1:0] rd;
    bit            got;
    string         rq;

    rst_n = 1'b0; cpu_req_valid = 1'b0; cpu_req_wr = 1'b0; cpu_req_addr = '0;
    cpu_req_wdata = '0; bus_gnt = 1'b0; bus_rdata = '0; snp_valid = 1'b0; snp_addr = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cpu_req_ready && !bus_req && !cpu_resp_valid, "R1",
        {29'd0, cpu_req_ready, bus_req, cpu_resp_valid}, 32'h4);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 after release
    chk(cpu_req_ready && !bus_req && !cpu_resp_valid, "R1",
        {29'd0, cpu_req_ready, bus_req, cpu_resp_valid}, 32'h4);

    for (int k = 0; k < NV; k++) begin
      logic [83:0] v;
      v  = VEC[k];
      rq = $sformatf("R%0d vec%0d", v[83:80], k);
      if (v[79:78] == 2'd2) begin
        do_snoop(v[77:66], rq);
      end else begin
        do_access(v[78:78] == 1'b1, v[77:66], v[65:34], 0, rq, kind, rd, got);
        chk(kind == int'(v[1:0]), rq, DW'(kind), DW'(v[1:0]));
        chk(got, rq, DW'(got), 1);
        if (v[79:78] == 2'd0) chk(rd == v[33:2], rq, rd, v[33:2]);
      end
    end

    // R9: pending read waits for grant; snoop of line 0x013 applied meanwhile
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_wr = 1'b0; cpu_req_addr = 12'h031;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk(bus_req && !bus_wr && bus_addr == 12'h031 && !cpu_req_ready, "R9",
        DW'(bus_addr), 32'h031);
    snp_valid = 1'b1; snp_addr = 12'h013;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    for (int w = 0; w < 3; w++) begin
      chk(bus_req && bus_addr == 12'h031 && !cpu_resp_valid && !cpu_req_ready, "R9",
          {bus_req, cpu_resp_valid, 18'd0, bus_addr}, {1'b1, 1'b0, 18'd0, 12'h031});
      @(posedge clk);
      @(negedge clk);
    end
    bus_gnt = 1'b1; bus_rdata = 32'hD0D0D0D0;
    @(posedge clk);
    @(negedge clk);
    bus_gnt = 1'b0;
    chk(cpu_resp_valid && cpu_resp_rdata == 32'hD0D0D0D0, "R9", cpu_resp_rdata, 32'hD0D0D0D0);
    do_access(1'b0, 12'h013, 32'h12121212, 0, "R9", kind, rd, got);
    chk(kind == 1, "R9 snoop while pending", DW'(kind), 1);

    // R10: snoop on the pending read's block forces a retry
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_wr = 1'b0; cpu_req_addr = 12'h042;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    snp_valid = 1'b1; snp_addr = 12'h042;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    bus_gnt = 1'b1; bus_rdata = 32'hAAAAAAAA;
    @(posedge clk);
    @(negedge clk);
    chk(!cpu_resp_valid && bus_req && bus_addr == 12'h042, "R10",
        {30'd0, cpu_resp_valid, bus_req}, 32'h1);
    bus_rdata = 32'hBBBBBBBB;
    @(posedge clk);
    @(negedge clk);
    bus_gnt = 1'b0;
    chk(cpu_resp_valid && cpu_resp_rdata == 32'hBBBBBBBB, "R10", cpu_resp_rdata, 32'hBBBBBBBB);
    do_access(1'b0, 12'h042, 32'h0, 0, "R10", kind, rd, got);
    chk(kind == 0 && rd == 32'hBBBBBBBB, "R10 hit after retry", rd, 32'hBBBBBBBB);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule